// File: doc/BRIEF.md
# Hardware Breakpoint Match Unit

This unit sits beside a processor pipeline and watches each instruction fetch and data access. Four address slots can be programmed. Each slot has its own trigger condition and its own coverage width. When an enabled slot matches, the unit requests a debug exception. An instruction-execute match is reported as a fault in the same cycle as the fetch, so the instruction can be held back before it runs. A data match is reported as a trap one cycle after the access, once the access has completed.

Three more sources feed the same status word:
- a single-step request on every retired instruction;
- a trap request when the incoming task carries a trap marker;
- a guard that faults any register write while it is armed.

A resume input masks execute matches for one cycle, so a restarted instruction does not fault again at once. Debug software reads the sticky status word to learn which causes fired, and clears bits by writing ones to them.

Top module: `bkpt_match_unit`

## Requirements
- R1: After reset, every register reads as zero and `dbg_fault` and `dbg_trap` are low.
- R2: Register offsets are as follows. Offsets 0 to 3 hold the slot addresses. Offset 4 is the control word. Offset 5 is the status word. Any other offset reads zero. Read data is valid in the same cycle as the request. Control layout: bit i enables slot i, bit 4 arms the write guard, bits 8+4i..9+4i hold the condition of slot i, and bits 10+4i..11+4i hold the length of slot i.
- R3: For a slot with condition 00 (execute), `dbg_fault` is high in the same cycle as a fetch (`bus_kind` 00) whose byte address equals the slot address exactly. The slot's status bit is set on the next edge. Data accesses never match an execute slot.
- R4: While `resume_flag` is high, execute matches raise no fault and set no status bit.
- R5: A slot with condition 01 matches data writes (`bus_kind` 10) only. Data reads (`bus_kind` 01) are ignored.
- R6: A slot with condition 11 matches both data reads and data writes.
- R7: A data access hits when two things hold. First, `bus_addr[31:2]` must equal the slot address bits 31:2. Second, `bus_be` must overlap the slot's byte region. The region depends on the length code:
  - 00 is one byte, at slot address bits 1:0.
  - 01 is two bytes, at the half selected by address bit 1.
  - 1x is all four bytes.
  `dbg_trap` is high in the cycle after a hit.
- R8: A slot that is disabled, or that has condition 10, never matches.
- R9: Every slot that matches in a cycle sets its own status bit (bit i for slot i) on the same edge.
- R10: `retire_valid` and `step_flag` high together raise `dbg_trap` in the next cycle and set status bit 4.
- R11: `task_switch` and `task_trap` high together raise `dbg_trap` in the next cycle and set status bit 5.
- R12: A register write while the guard is armed has the following effects:
  - the write is dropped;
  - `dbg_fault` is high in that cycle;
  - status bit 6 is set;
  - the guard disarms, so the handler can then write.
- R13: Status bits stay set until a write of ones to offset 5 clears them. A cause that arrives in the same cycle as a clear of its bit leaves the bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_valid | input | 1 | Register access request |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, same cycle |
| bus_valid | input | 1 | A bus access is present |
| bus_kind | input | 2 | 00 fetch, 01 data read, 10 data write, 11 none |
| bus_addr | input | 32 | Byte address of the access |
| bus_be | input | 4 | Byte enables within the 4-byte word |
| resume_flag | input | 1 | Masks execute matches this cycle |
| step_flag | input | 1 | Single-step mode |
| retire_valid | input | 1 | An instruction retires this cycle |
| task_switch | input | 1 | A task switch takes place this cycle |
| task_trap | input | 1 | Trap marker of the incoming task |
| dbg_fault | output | 1 | Fault-style debug request (execute match or guard) |
| dbg_trap | output | 1 | Trap-style debug request (data, step, task) |

## Verification
The bench probes the edges of each coverage region:
- a byte enable just outside a word-length region, which a comparator with the wrong shift would report as a hit;
- a fetch one byte past an execute address, which a masked comparison would wrongly match;
- an adjacent word, which a comparator that drops upper address bits would match.

It checks that a read does not trigger a write-only slot, and that a disabled slot or one with the reserved condition stays silent. It also checks that one access landing in two slots sets both status bits.

For the status word, it clears a bit in the same cycle that the bit is set; a clear-wins design would lose the cause. It also makes sure a guarded write leaves the slot address unchanged, and that the guard lets the next write through.

// File: rtl/bkpt_pkg.sv
`timescale 1ns/1ps
// Shared encodings for the breakpoint match unit.
// Assumes at most four slots, so that slot offsets stay below the control offset.
package bkpt_pkg;
    typedef enum logic [1:0] {
        COND_EXEC  = 2'b00,
        COND_WRITE = 2'b01,
        COND_RSVD  = 2'b10,
        COND_RDWR  = 2'b11
    } cond_e;

    typedef enum logic [1:0] {
        LEN_BYTE  = 2'b00,
        LEN_HALF  = 2'b01,
        LEN_FULL  = 2'b11
    } len_e;

    typedef enum logic [1:0] {
        BUS_FETCH = 2'b00,
        BUS_RD    = 2'b01,
        BUS_WR    = 2'b10,
        BUS_NONE  = 2'b11
    } bus_kind_e;

    localparam logic [2:0] OFF_CTRL   = 3'd4;
    localparam logic [2:0] OFF_STATUS = 3'd5;
    localparam int unsigned CTRL_FIELD_BASE   = 8;
    localparam int unsigned CTRL_FIELD_STRIDE = 4;
endpackage

// File: rtl/bkpt_slot_cmp.sv
`timescale 1ns/1ps
// One address comparator for a single slot.
// Execute matches need an exact byte address on a fetch. Data matches compare
// the 4-byte word address and test the byte enables against the slot region.
// Purely combinational. Assumes AW >= 3.
module bkpt_slot_cmp
    import bkpt_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input  logic          en,
    input  logic [1:0]    cond,
    input  logic [1:0]    len,
    input  logic [AW-1:0] slot_addr,
    input  logic          bus_valid,
    input  logic [1:0]    bus_kind,
    input  logic [AW-1:0] bus_addr,
    input  logic [3:0]    bus_be,
    output logic          exec_hit,
    output logic          data_hit
);
    logic [3:0] region;
    logic       same_word;
    logic       kind_ok;

    // Byte region covered by the slot inside its 4-byte word.
    always_comb begin
        case (len)
            LEN_BYTE: region = 4'b0001 << slot_addr[1:0];
            LEN_HALF: region = 4'b0011 << {slot_addr[1], 1'b0};
            default:  region = 4'b1111;
        endcase
    end

    // Does the access kind qualify for this slot's data condition?
    always_comb begin
        kind_ok = 1'b0;
        if (bus_kind == BUS_WR)
            kind_ok = (cond == COND_WRITE) || (cond == COND_RDWR);
        else if (bus_kind == BUS_RD)
            kind_ok = (cond == COND_RDWR);
    end

    assign same_word = (bus_addr[AW-1:2] == slot_addr[AW-1:2]);
    assign exec_hit  = en && bus_valid && (cond == COND_EXEC)
                       && (bus_kind == BUS_FETCH) && (bus_addr == slot_addr);
    assign data_hit  = en && bus_valid && kind_ok && same_word
                       && (|(bus_be & region));
endmodule

// File: rtl/bkpt_regs.sv
`timescale 1ns/1ps
// Register file: slot addresses, control word, sticky status word.
// Assumes AW <= DW and NS <= 4.
// Writes are dropped while the guard is armed. A blocked write raises
// guard_fault and disarms the guard.
// Status bit layout: [NS-1:0] slots, NS step, NS+1 task, NS+2 guard.
module bkpt_regs
    import bkpt_pkg::*;
#(
    parameter int unsigned AW = 32,
    parameter int unsigned DW = 32,
    parameter int unsigned NS = 4,
    localparam int unsigned SW = NS + 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   reg_valid,
    input  logic                   reg_write,
    input  logic [2:0]             reg_addr,
    input  logic [DW-1:0]          reg_wdata,
    output logic [DW-1:0]          reg_rdata,
    input  logic [SW-2:0]          status_set,
    output logic [NS-1:0][AW-1:0]  slot_addr,
    output logic [NS-1:0]          slot_en,
    output logic [NS-1:0][1:0]     slot_cond,
    output logic [NS-1:0][1:0]     slot_len,
    output logic                   guard_fault
);
    logic          guard_en;
    logic [SW-1:0] status;
    logic [SW-1:0] clr_mask;
    logic          wr_ok;
    logic [DW-1:0] ctrl_rd;
    logic          unused_wdata_bits;

    assign unused_wdata_bits = ^reg_wdata;
    assign guard_fault = reg_valid && reg_write && guard_en;
    assign wr_ok       = reg_valid && reg_write && !guard_en;
    assign clr_mask    = (wr_ok && reg_addr == OFF_STATUS) ? reg_wdata[SW-1:0] : '0;

    // Register state update: writes, guard disarm, sticky status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_addr <= '0;
            slot_en   <= '0;
            slot_cond <= '0;
            slot_len  <= '0;
            guard_en  <= 1'b0;
            status    <= '0;
        end else begin
            if (wr_ok) begin
                for (int i = 0; i < NS; i++)
                    if (reg_addr == 3'(i)) slot_addr[i] <= reg_wdata[AW-1:0];
                if (reg_addr == OFF_CTRL) begin
                    slot_en  <= reg_wdata[NS-1:0];
                    guard_en <= reg_wdata[NS];
                    for (int i = 0; i < NS; i++) begin
                        slot_cond[i] <= reg_wdata[CTRL_FIELD_BASE + CTRL_FIELD_STRIDE*i +: 2];
                        slot_len[i]  <= reg_wdata[CTRL_FIELD_BASE + CTRL_FIELD_STRIDE*i + 2 +: 2];
                    end
                end
            end
            if (guard_fault) guard_en <= 1'b0;
            status <= (status & ~clr_mask) | {guard_fault, status_set};
        end
    end

    // Control word view for readback.
    always_comb begin
        ctrl_rd = '0;
        ctrl_rd[NS-1:0] = slot_en;
        ctrl_rd[NS]     = guard_en;
        for (int i = 0; i < NS; i++) begin
            ctrl_rd[CTRL_FIELD_BASE + CTRL_FIELD_STRIDE*i +: 2]     = slot_cond[i];
            ctrl_rd[CTRL_FIELD_BASE + CTRL_FIELD_STRIDE*i + 2 +: 2] = slot_len[i];
        end
    end

    // Same-cycle read mux.
    always_comb begin
        reg_rdata = '0;
        if (reg_valid && !reg_write) begin
            for (int i = 0; i < NS; i++)
                if (reg_addr == 3'(i)) reg_rdata = DW'(slot_addr[i]);
            if (reg_addr == OFF_CTRL)   reg_rdata = ctrl_rd;
            if (reg_addr == OFF_STATUS) reg_rdata = DW'(status);
        end
    end

    // R12: a guarded write leaves the addresses intact, disarms the guard and logs the cause.
    assert_guard_blocks_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
        guard_fault |=> (!guard_en && status[NS+2] && slot_addr == $past(slot_addr)));

    // R13: bits not being cleared stay set.
    assert_status_sticky_R13: assert property (@(posedge clk) disable iff (!rst_n)
        ((status & $past(status & ~clr_mask)) == $past(status & ~clr_mask)));

    // R9: every requested cause lands in the status word on the next edge.
    assert_causes_recorded_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((status[SW-2:0] & $past(status_set)) == $past(status_set)));
endmodule

// File: rtl/bkpt_match_unit.sv
`timescale 1ns/1ps
// Breakpoint match unit top.
// Holds NS slot comparators and the register file, and produces the two request types:
//   - fault, same cycle: execute match or guarded write;
//   - trap, one cycle later: data match, single step, task trap.
// Assumes the fetch address is the first byte of the instruction.
module bkpt_match_unit
    import bkpt_pkg::*;
#(
    parameter int unsigned AW = 32,
    parameter int unsigned DW = 32,
    parameter int unsigned NS = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_valid,
    input  logic          reg_write,
    input  logic [2:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          bus_valid,
    input  logic [1:0]    bus_kind,
    input  logic [AW-1:0] bus_addr,
    input  logic [3:0]    bus_be,
    input  logic          resume_flag,
    input  logic          step_flag,
    input  logic          retire_valid,
    input  logic          task_switch,
    input  logic          task_trap,
    output logic          dbg_fault,
    output logic          dbg_trap
);
    logic [NS-1:0][AW-1:0] slot_addr;
    logic [NS-1:0]         slot_en;
    logic [NS-1:0][1:0]    slot_cond;
    logic [NS-1:0][1:0]    slot_len;
    logic [NS-1:0]         exec_hits;
    logic [NS-1:0]         data_hits;
    logic [NS-1:0]         exec_fire;
    logic                  guard_fault;
    logic                  step_ev;
    logic                  task_ev;
    logic                  trap_q;

    bkpt_regs #(.AW(AW), .DW(DW), .NS(NS)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_valid   (reg_valid),
        .reg_write   (reg_write),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .status_set  ({task_ev, step_ev, exec_fire | data_hits}),
        .slot_addr   (slot_addr),
        .slot_en     (slot_en),
        .slot_cond   (slot_cond),
        .slot_len    (slot_len),
        .guard_fault (guard_fault)
    );

    for (genvar g = 0; g < NS; g++) begin : g_slot
        bkpt_slot_cmp #(.AW(AW)) u_cmp (
            .en        (slot_en[g]),
            .cond      (slot_cond[g]),
            .len       (slot_len[g]),
            .slot_addr (slot_addr[g]),
            .bus_valid (bus_valid),
            .bus_kind  (bus_kind),
            .bus_addr  (bus_addr),
            .bus_be    (bus_be),
            .exec_hit  (exec_hits[g]),
            .data_hit  (data_hits[g])
        );
    end

    assign exec_fire = resume_flag ? '0 : exec_hits;
    assign step_ev   = retire_valid && step_flag;
    assign task_ev   = task_switch && task_trap;
    assign dbg_fault = (|exec_fire) || guard_fault;
    assign dbg_trap  = trap_q;

    // Trap-style request, one cycle after the cause.
    always_ff @(posedge clk) begin
        if (!rst_n) trap_q <= 1'b0;
        else        trap_q <= (|data_hits) || step_ev || task_ev;
    end

    // R3: a fault needs an unmasked fetch or a register write.
    assert_fault_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_fault |-> ((bus_valid && bus_kind == BUS_FETCH && !resume_flag)
                       || (reg_valid && reg_write)));

    // R4: resume masks every execute fault.
    assert_resume_masks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (resume_flag && !(reg_valid && reg_write)) |-> !dbg_fault);

    // R10: a trap follows a data access, a retired step or a task trap.
    assert_trap_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_trap |-> $past((bus_valid && (bus_kind == BUS_RD || bus_kind == BUS_WR))
                           || (retire_valid && step_flag) || (task_switch && task_trap)));
endmodule

// File: tb/bkpt_match_unit_test.sv
`timescale 1ns/1ps
module bkpt_match_unit_test;
    import bkpt_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_valid, reg_write;
    logic [2:0]  reg_addr;
    logic [31:0] reg_wdata, reg_rdata;
    logic        bus_valid;
    logic [1:0]  bus_kind;
    logic [31:0] bus_addr;
    logic [3:0]  bus_be;
    logic        resume_flag, step_flag, retire_valid, task_switch, task_trap;
    logic        dbg_fault, dbg_trap;

    localparam logic [31:0] CTRL = 32'h00F3500F;

    always #2.5 clk = ~clk;

    bkpt_match_unit uut (.*);

    typedef struct {
        int          at;
        int          sel;
        logic [31:0] val;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   checks = 0;
    int   failures = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: pop the items due this cycle and compare.
    always @(negedge clk) begin
        exp_t rest[$];
        logic [31:0] act;
        rest = {};
        foreach (q[k]) begin
            if (q[k].at == cyc) begin
                act = (q[k].sel == 0) ? {31'b0, dbg_fault} :
                      (q[k].sel == 1) ? {31'b0, dbg_trap} : reg_rdata;
                checks++;
                if (act !== q[k].val) begin
                    failures++;
                    $display("FAIL %s: actual=%h expected=%h", q[k].tag, act, q[k].val);
                end
            end else begin
                rest.push_back(q[k]);
            end
        end
        q = rest;
    end

    task automatic expect_at(int d, int sel, logic [31:0] v, string tag);
        q.push_back('{cyc + d, sel, v, tag});
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        reg_valid = 0; reg_write = 0; reg_addr = 0; reg_wdata = 0;
        bus_valid = 0; bus_kind = BUS_NONE; bus_addr = 0; bus_be = 0;
        resume_flag = 0; step_flag = 0; retire_valid = 0;
        task_switch = 0; task_trap = 0;
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        tick();
        reg_valid = 1; reg_write = 1; reg_addr = a; reg_wdata = d;
    endtask

    task automatic rd_chk(logic [2:0] a, logic [31:0] v, string tag);
        tick();
        reg_valid = 1; reg_addr = a;
        expect_at(0, 2, v, tag);
    endtask

    task automatic bus(logic [1:0] k, logic [31:0] a, logic [3:0] be);
        tick();
        bus_valid = 1; bus_kind = k; bus_addr = a; bus_be = be;
    endtask

    task automatic data_chk(logic [1:0] k, logic [31:0] a, logic [3:0] be, logic hit, string tag);
        bus(k, a, be);
        expect_at(0, 0, 0, tag);
        expect_at(1, 1, {31'b0, hit}, tag);
    endtask

    task automatic fetch_chk(logic [31:0] a, logic res, logic hit, string tag);
        bus(BUS_FETCH, a, 4'hF);
        resume_flag = res;
        expect_at(0, 0, {31'b0, hit}, tag);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        rst_n = 0;
        reg_valid = 0; reg_write = 0; reg_addr = 0; reg_wdata = 0;
        bus_valid = 0; bus_kind = BUS_NONE; bus_addr = 0; bus_be = 0;
        resume_flag = 0; step_flag = 0; retire_valid = 0;
        task_switch = 0; task_trap = 0;
        repeat (5) @(posedge clk);
        #1 rst_n = 1;

        // R1 reset state
        rd_chk(OFF_STATUS, 0, "R1 status");
        expect_at(0, 0, 0, "R1 fault");
        expect_at(0, 1, 0, "R1 trap");
        rd_chk(OFF_CTRL, 0, "R1 ctrl");
        rd_chk(0, 0, "R1 slot0");

        // R2 programming and readback
        wr(0, 32'h1000); wr(1, 32'h2002); wr(2, 32'h3001); wr(3, 32'h4000);
        wr(OFF_CTRL, CTRL);
        rd_chk(0, 32'h1000, "R2 slot0");
        rd_chk(1, 32'h2002, "R2 slot1");
        rd_chk(OFF_CTRL, CTRL, "R2 ctrl");
        rd_chk(3'd6, 0, "R2 unmapped");

        // R3 execute match: exact address only, fetches only
        fetch_chk(32'h1000, 0, 1, "R3 exec hit");
        rd_chk(OFF_STATUS, 32'h1, "R3 status");
        fetch_chk(32'h1001, 0, 0, "R3 off by one");
        data_chk(BUS_RD, 32'h1000, 4'b0001, 0, "R3 data on exec slot");
        wr(OFF_STATUS, 32'h1);
        rd_chk(OFF_STATUS, 0, "R13 write-one clear");

        // R4 resume masks execute
        fetch_chk(32'h1000, 1, 0, "R4 resume");
        rd_chk(OFF_STATUS, 0, "R4 status");

        // R5 write-only slot, R7 word region
        data_chk(BUS_WR, 32'h2000, 4'b0001, 0, "R7 word outside");
        data_chk(BUS_WR, 32'h2000, 4'b0100, 1, "R5 write hit");
        rd_chk(OFF_STATUS, 32'h2, "R5 status");
        data_chk(BUS_RD, 32'h2000, 4'b1100, 0, "R5 read ignored");
        data_chk(BUS_WR, 32'h2000, 4'b1000, 1, "R7 word upper byte");
        wr(OFF_STATUS, 32'h7F);

        // R6 read-write byte slot
        data_chk(BUS_RD, 32'h3000, 4'b0010, 1, "R6 read hit");
        data_chk(BUS_WR, 32'h3000, 4'b0011, 1, "R6 write hit");
        data_chk(BUS_RD, 32'h3000, 4'b1101, 0, "R7 byte outside");
        data_chk(BUS_RD, 32'h3004, 4'b0010, 0, "R7 next word");
        rd_chk(OFF_STATUS, 32'h4, "R6 status");
        wr(OFF_STATUS, 32'h7F);

        // R7 full-word region
        data_chk(BUS_RD, 32'h4000, 4'b1000, 1, "R7 dword");
        data_chk(BUS_WR, 32'h4004, 4'b1111, 0, "R7 dword next word");
        rd_chk(OFF_STATUS, 32'h8, "R7 status");
        wr(OFF_STATUS, 32'h7F);

        // R8 disabled slot and reserved condition
        wr(OFF_CTRL, CTRL & ~32'h8);
        data_chk(BUS_RD, 32'h4000, 4'b1111, 0, "R8 disabled");
        wr(OFF_CTRL, 32'h00E3500F);
        data_chk(BUS_RD, 32'h4000, 4'b1111, 0, "R8 reserved cond");
        rd_chk(OFF_STATUS, 0, "R8 status");

        // R9 two slots in one access
        wr(OFF_CTRL, CTRL);
        wr(2, 32'h4001);
        data_chk(BUS_RD, 32'h4000, 4'b0010, 1, "R9 trap");
        rd_chk(OFF_STATUS, 32'hC, "R9 both bits");
        wr(OFF_STATUS, 32'h7F);

        // R13 set beats clear in the same cycle
        bus(BUS_RD, 32'h4000, 4'b0010);
        reg_valid = 1; reg_write = 1; reg_addr = OFF_STATUS; reg_wdata = 32'hC;
        expect_at(1, 1, 1, "R13 trap");
        rd_chk(OFF_STATUS, 32'hC, "R13 set beats clear");
        wr(OFF_STATUS, 32'h7F);

        // R10 single step
        tick(); step_flag = 1; retire_valid = 1;
        expect_at(1, 1, 1, "R10 step trap");
        rd_chk(OFF_STATUS, 32'h10, "R10 status");
        tick(); step_flag = 1;
        expect_at(1, 1, 0, "R10 no retire");
        wr(OFF_STATUS, 32'h7F);

        // R11 task switch trap
        tick(); task_switch = 1; task_trap = 1;
        expect_at(1, 1, 1, "R11 task trap");
        rd_chk(OFF_STATUS, 32'h20, "R11 status");
        tick(); task_switch = 1;
        expect_at(1, 1, 0, "R11 no marker");
        wr(OFF_STATUS, 32'h7F);

        // R12 register guard
        wr(OFF_CTRL, CTRL | 32'h10);
        wr(0, 32'h5555);
        expect_at(0, 0, 1, "R12 fault");
        rd_chk(0, 32'h1000, "R12 write dropped");
        rd_chk(OFF_STATUS, 32'h40, "R12 status");
        rd_chk(OFF_CTRL, CTRL, "R12 guard disarmed");
        wr(0, 32'h6000);
        expect_at(0, 0, 0, "R12 next write no fault");
        rd_chk(0, 32'h6000, "R12 write after disarm");

        tick(); tick(); tick();
        if (q.size() != 0) begin
            failures++;
            $display("FAIL scoreboard: actual=%0d pending expected=0", q.size());
        end
        finish_run();
    end
endmodule